// File: doc/BRIEF.md
# SMBus Host Protocol Register Front-End

This block holds the software-visible registers of a simple SMBus host controller and runs the byte sequence of one transaction. Software writes a slave address (7-bit address in bits 7:1), an optional command byte and up to two data bytes over an internal 8-bit register bus. It then writes a protocol code. That write launches a Quick, Send/Receive Byte, Read/Write Byte Data or Read/Write Word Data transaction.

The block does not drive SCL or SDA. It issues one abstract operation at a time to a bit-level engine: start, write byte, read byte, or stop. Each operation is held until the engine returns a one-cycle completion pulse. When the transaction ends, the block reports success or failure in a status register and can raise an interrupt.

Top module: `smbus_host_regs`

## Requirements
- R1: Register offsets are: 0 protocol, 1 status, 2 slave address, 3 command, 4 data0, 5 data1. Offsets 0, 2, 3, 4 and 5 read back the last value written or captured. Offsets 6 and 7 read as zero.
- R2: Engine operations are encoded as 0 start, 1 write byte, 2 read byte and 3 stop. `eng_req_o` and the presented operation stay unchanged until the cycle in which `eng_done_i` is high. After the stop completes, `eng_req_o` drops.
- R3: Codes 0x02 and 0x03 (Quick) produce start, then the address byte with bit 0 equal to code bit 0, then stop.
- R4: Code 0x04 produces start, address with bit 0 = 0, data0, stop. Code 0x05 produces start, address with bit 0 = 1, a read with NACK whose byte is stored in data0, stop. No command byte is sent.
- R5: Code 0x06 produces start, address+W, command, data0, stop. Code 0x07 produces start, address+W, command, repeated start, address+R, a read with NACK into data0, stop.
- R6: Code 0x08 writes command, data0 and data1 in that order. Code 0x09 follows the repeated-start form of R5 and performs two reads: the first is ACKed and goes to data0, the second is NACKed and goes to data1.
- R7: A successful transaction sets status to 0x80. Status reads 0x00 from the launch until the transaction ends.
- R8: If the slave does not ACK a written byte, no further bytes are sent, a stop follows, and status becomes 0x01 with bit 7 clear.
- R9: A protocol code outside 0x02..0x09 sets status to 0x02 and issues no engine request.
- R10: A protocol write while a transaction is running is ignored: no sequence change and no change to the protocol register.
- R11: Any write to offset 1 clears status. If that write falls in the cycle in which a transaction completes, the completion value is kept.
- R12: `irq_o` is high exactly when status is nonzero and `irq_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register offset for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| eng_req_o | output | 1 | Operation request to the bit engine |
| eng_op_o | output | 2 | Operation code (R2) |
| eng_byte_o | output | 8 | Byte to transmit |
| eng_nack_o | output | 1 | Host sends NACK after this read |
| eng_done_i | input | 1 | One-cycle completion of the current operation |
| eng_ack_i | input | 1 | Slave acknowledged the written byte |
| eng_byte_i | input | 8 | Byte received by a read |

## Verification
Two things can collide in one cycle: a software write that clears status, and the engine's completion of the final stop, which loads the result into status. The bench's engine model raises its stop completion and, in the same cycle, forces a write to offset 1. Status must then read 0x80 rather than zero. A second collision is a protocol write issued while a word transfer is running. This is judged by the engine scoreboard, which fails on any unexpected operation, and by reading back the protocol register.

// File: rtl/smh_pkg.sv
package smh_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} eng_op_e;

  typedef struct packed {
    logic       valid;
    logic       rd;
    logic       has_cmd;
    logic [1:0] nbytes;
  } proto_t;

  localparam int REG_PROTO = 0;
  localparam int REG_STAT  = 1;
  localparam int REG_ADDR  = 2;
  localparam int REG_CMD   = 3;
  localparam int REG_DATA0 = 4;
  localparam int NDATA     = 2;

  localparam logic [7:0] STAT_DONE   = 8'h80;
  localparam logic [7:0] STAT_NOACK  = 8'h01;
  localparam logic [7:0] STAT_BADCMD = 8'h02;
endpackage

// File: rtl/smh_proto_decode.sv
module smh_proto_decode
  import smh_pkg::*;
(
  input  logic [7:0] code_i,
  output proto_t     dec_o
);
  always_comb begin
    dec_o    = '0;
    dec_o.rd = code_i[0];
    unique case (code_i[7:1])
      7'd1: dec_o.valid = 1'b1;                                   // quick
      7'd2: begin dec_o.valid = 1'b1; dec_o.nbytes = 2'd1; end    // byte
      7'd3: begin dec_o.valid = 1'b1; dec_o.has_cmd = 1'b1; dec_o.nbytes = 2'd1; end
      7'd4: begin dec_o.valid = 1'b1; dec_o.has_cmd = 1'b1; dec_o.nbytes = 2'd2; end
      default: dec_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/smh_seq.sv
module smh_seq
  import smh_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  proto_t          dec_i,
  input  logic [7:0]      addr_i,
  input  logic [7:0]      cmd_i,
  input  logic [1:0][7:0] wdata_i,
  input  logic            eng_done_i,
  input  logic            eng_ack_i,
  input  logic [7:0]      eng_byte_i,
  output logic            eng_req_o,
  output eng_op_e         eng_op_o,
  output logic [7:0]      eng_byte_o,
  output logic            eng_nack_o,
  output logic            busy_o,
  output logic            fin_o,
  output logic            fin_err_o,
  output logic            cap_o,
  output logic            cap_idx_o,
  output logic [7:0]      cap_byte_o
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_CMD, ST_WDATA, ST_RSTART, ST_RADDR, ST_RDATA, ST_STOP
  } st_e;

  st_e    st_q, st_d;
  proto_t cfg_q, cfg_d;
  logic   idx_q, idx_d, err_q, err_d;
  logic   last;

  assign last = (({1'b0, idx_q} + 2'd1) == cfg_q.nbytes);

  always_comb begin
    st_d = st_q; cfg_d = cfg_q; idx_d = idx_q; err_d = err_q;
    unique case (st_q)
      ST_IDLE: if (launch_i) begin
        st_d = ST_START; cfg_d = dec_i; idx_d = 1'b0; err_d = 1'b0;
      end
      ST_START:  if (eng_done_i) st_d = ST_ADDR;
      ST_ADDR: if (eng_done_i) begin
        if (!eng_ack_i)                begin err_d = 1'b1; st_d = ST_STOP; end
        else if (cfg_q.has_cmd)        st_d = ST_CMD;
        else if (cfg_q.nbytes == 2'd0) st_d = ST_STOP;
        else if (cfg_q.rd)             st_d = ST_RDATA;
        else                           st_d = ST_WDATA;
      end
      ST_CMD: if (eng_done_i) begin
        if (!eng_ack_i)                begin err_d = 1'b1; st_d = ST_STOP; end
        else if (cfg_q.rd)             st_d = ST_RSTART;
        else if (cfg_q.nbytes == 2'd0) st_d = ST_STOP;
        else                           st_d = ST_WDATA;
      end
      ST_WDATA: if (eng_done_i) begin
        if (!eng_ack_i) begin err_d = 1'b1; st_d = ST_STOP; end
        else if (last)  st_d = ST_STOP;
        else            idx_d = 1'b1;
      end
      ST_RSTART: if (eng_done_i) st_d = ST_RADDR;
      ST_RADDR: if (eng_done_i) begin
        if (!eng_ack_i) begin err_d = 1'b1; st_d = ST_STOP; end
        else            st_d = ST_RDATA;
      end
      ST_RDATA: if (eng_done_i) begin
        if (last) st_d = ST_STOP;
        else      idx_d = 1'b1;
      end
      ST_STOP: if (eng_done_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cfg_q <= '0; idx_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; cfg_q <= cfg_d; idx_q <= idx_d; err_q <= err_d;
    end
  end

  always_comb begin
    eng_byte_o = 8'h00;
    unique case (st_q)
      ST_START, ST_RSTART: eng_op_o = OP_START;
      ST_RDATA:            eng_op_o = OP_READ;
      ST_STOP:             eng_op_o = OP_STOP;
      default:             eng_op_o = OP_WRITE;
    endcase
    unique case (st_q)
      ST_ADDR:  eng_byte_o = {addr_i[7:1], cfg_q.rd & ~cfg_q.has_cmd};
      ST_RADDR: eng_byte_o = {addr_i[7:1], 1'b1};
      ST_CMD:   eng_byte_o = cmd_i;
      ST_WDATA: eng_byte_o = wdata_i[idx_q];
      default:  eng_byte_o = 8'h00;
    endcase
  end

  assign eng_req_o  = (st_q != ST_IDLE);
  assign eng_nack_o = (st_q == ST_RDATA) && last;
  assign busy_o     = eng_req_o;
  assign fin_o      = (st_q == ST_STOP) && eng_done_i;
  assign fin_err_o  = err_q;
  assign cap_o      = (st_q == ST_RDATA) && eng_done_i;
  assign cap_idx_o  = idx_q;
  assign cap_byte_o = eng_byte_i;

  // R2
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && !eng_done_i) |=> (eng_req_o && $stable(eng_op_o) && $stable(eng_nack_o)));
  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && eng_op_o == OP_STOP && eng_done_i) |=> !eng_req_o);
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smh_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          irq_en_i,
  output logic          irq_o,
  output logic          eng_req_o,
  output logic [1:0]    eng_op_o,
  output logic [7:0]    eng_byte_o,
  output logic          eng_nack_o,
  input  logic          eng_done_i,
  input  logic          eng_ack_i,
  input  logic [7:0]    eng_byte_i
);
  localparam logic [AW-1:0] A_PROTO = AW'(REG_PROTO);
  localparam logic [AW-1:0] A_STAT  = AW'(REG_STAT);
  localparam logic [AW-1:0] A_ADDR  = AW'(REG_ADDR);
  localparam logic [AW-1:0] A_CMD   = AW'(REG_CMD);

  logic [7:0]            proto_q, stat_q, addr_q, cmd_q;
  logic [NDATA-1:0][7:0] data_q;
  proto_t                dec;
  eng_op_e               op;
  logic busy, fin, fin_err, cap, cap_idx, launch, bad, wr_proto, wr_stat;
  logic [7:0] cap_byte;

  smh_proto_decode u_dec (.code_i(reg_wdata_i), .dec_o(dec));

  assign wr_proto = reg_wr_i && (reg_addr_i == A_PROTO) && !busy;
  assign wr_stat  = reg_wr_i && (reg_addr_i == A_STAT);
  assign launch   = wr_proto && dec.valid;
  assign bad      = wr_proto && !dec.valid;

  smh_seq u_seq (
    .clk_i, .rst_ni, .launch_i(launch), .dec_i(dec),
    .addr_i(addr_q), .cmd_i(cmd_q), .wdata_i(data_q),
    .eng_done_i, .eng_ack_i, .eng_byte_i,
    .eng_req_o, .eng_op_o(op), .eng_byte_o, .eng_nack_o,
    .busy_o(busy), .fin_o(fin), .fin_err_o(fin_err),
    .cap_o(cap), .cap_idx_o(cap_idx), .cap_byte_o(cap_byte)
  );
  assign eng_op_o = op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      proto_q <= '0; stat_q <= '0; addr_q <= '0; cmd_q <= '0;
    end else begin
      if (wr_proto) proto_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_ADDR) addr_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == A_CMD)  cmd_q  <= reg_wdata_i;
      if (fin)          stat_q <= fin_err ? STAT_NOACK : STAT_DONE;  // completion beats clear
      else if (launch)  stat_q <= 8'h00;
      else if (bad)     stat_q <= STAT_BADCMD;
      else if (wr_stat) stat_q <= 8'h00;
    end
  end

  for (genvar i = 0; i < NDATA; i++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   data_q[i] <= '0;
      else if (cap && cap_idx == i[0])               data_q[i] <= cap_byte;
      else if (reg_wr_i && reg_addr_i == AW'(REG_DATA0 + i)) data_q[i] <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i == A_PROTO)      reg_rdata_o = proto_q;
    else if (reg_addr_i == A_STAT)  reg_rdata_o = stat_q;
    else if (reg_addr_i == A_ADDR)  reg_rdata_o = addr_q;
    else if (reg_addr_i == A_CMD)   reg_rdata_o = cmd_q;
    else begin
      for (int i = 0; i < NDATA; i++)
        if (reg_addr_i == AW'(REG_DATA0 + i)) reg_rdata_o = data_q[i];
    end
  end

  assign irq_o = irq_en_i && (stat_q != 8'h00);

  // R7
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (stat_q == 8'h00));
  // R8
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat_q[7] && (stat_q[4:0] != 5'd0)));
  // R10
  proto_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == A_PROTO && busy) |=> $stable(proto_q));
  // R11
  fin_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && wr_stat) |=> (stat_q != 8'h00));
endmodule

// File: tb/smbus_host_regs_test.sv
`timescale 1ns/1ps
module smbus_host_regs_test;
  typedef struct { logic [1:0] op; logic [7:0] b; logic nk; } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic drv_wr = 1'b0, eng_clr = 1'b0;
  logic [2:0] drv_addr = '0;
  logic [7:0] drv_wd = '0;
  logic irq_en = 1'b0;
  logic done = 1'b0, ack = 1'b1;
  logic [7:0] byte_in = '0;
  logic [7:0] rdata, eng_byte;
  logic irq, eng_req, eng_nack;
  logic [1:0] eng_op;

  item_t q[$];
  int checks = 0, errors = 0, opcnt = 0, nack_at = -1;
  bit clr_on_stop = 0, ended = 0;

  always #4 clk = ~clk;

  smbus_host_regs #(.AW(3)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(drv_wr | eng_clr), .reg_addr_i(eng_clr ? 3'd1 : drv_addr), .reg_wdata_i(drv_wd),
    .reg_rdata_o(rdata), .irq_en_i(irq_en), .irq_o(irq),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_byte_o(eng_byte), .eng_nack_o(eng_nack),
    .eng_done_i(done), .eng_ack_i(ack), .eng_byte_i(byte_in)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic nk);
    item_t it; it.op = op; it.b = b; it.nk = nk; q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); drv_wr = 1'b1; drv_addr = a; drv_wd = d;
    @(negedge clk); drv_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); drv_addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || eng_req);
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] code, input int nk_at);
    opcnt = 0; nack_at = nk_at;
    wr(3'd0, code);
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req) begin
        item_t it;
        if (q.size() == 0) begin
          chk("R2 unexpected engine op", {6'd0, eng_op}, 8'hff);
          it.op = eng_op; it.b = 8'h00; it.nk = 1'b0;
        end else begin
          it = q.pop_front();
          chk("R2 op order", {6'd0, eng_op}, {6'd0, it.op});
          if (it.op == 2'd1) chk("R3-6 tx byte", eng_byte, it.b);
          if (it.op == 2'd2) chk("R6 nack flag", {7'd0, eng_nack}, {7'd0, it.nk});
        end
        repeat (2) @(negedge clk);
        done = 1'b1; ack = (opcnt != nack_at); byte_in = it.b;
        if (clr_on_stop && eng_op == 2'd3) eng_clr = 1'b1;
        opcnt++;
        @(negedge clk); done = 1'b0; eng_clr = 1'b0; ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    // reset state
    rd(3'd1, d); chk("R7 reset status", d, 8'h00);
    rd(3'd4, d); chk("R1 reset data0", d, 8'h00);
    chk("R12 reset irq", {7'd0, irq}, 8'h00);
    chk("R2 reset req", {7'd0, eng_req}, 8'h00);

    // R1 register readback
    wr(3'd2, 8'hA0); wr(3'd3, 8'h12); wr(3'd4, 8'h34); wr(3'd5, 8'h56);
    rd(3'd2, d); chk("R1 addr", d, 8'hA0);
    rd(3'd3, d); chk("R1 cmd", d, 8'h12);
    rd(3'd5, d); chk("R1 data1", d, 8'h56);
    rd(3'd6, d); chk("R1 unused 6", d, 8'h00);
    rd(3'd7, d); chk("R1 unused 7", d, 8'h00);

    // R6 word write, with R10 protocol write during busy
    push(0,0,0); push(1,8'hA0,0); push(1,8'h12,0); push(1,8'h34,0); push(1,8'h56,0); push(3,0,0);
    launch(8'h08, -1);
    repeat (4) @(negedge clk);
    rd(3'd1, d); chk("R7 status while busy", d, 8'h00);
    wr(3'd0, 8'h02);
    wait_idle();
    rd(3'd0, d); chk("R10 protocol kept", d, 8'h08);
    rd(3'd1, d); chk("R7 done status", d, 8'h80);
    chk("R12 irq masked", {7'd0, irq}, 8'h00);
    irq_en = 1'b1; #1;
    chk("R12 irq enabled", {7'd0, irq}, 8'h01);
    wr(3'd1, 8'h5A);
    rd(3'd1, d); chk("R11 status cleared", d, 8'h00);
    chk("R12 irq after clear", {7'd0, irq}, 8'h00);

    // R5 read byte data
    push(0,0,0); push(1,8'hA0,0); push(1,8'h12,0); push(0,0,0); push(1,8'hA1,0);
    push(2,8'h9C,1); push(3,0,0);
    launch(8'h07, -1); wait_idle();
    rd(3'd4, d); chk("R5 read data0", d, 8'h9C);
    rd(3'd5, d); chk("R5 data1 untouched", d, 8'h56);
    wr(3'd1, 0);

    // R5 write byte data
    push(0,0,0); push(1,8'hA0,0); push(1,8'h12,0); push(1,8'h9C,0); push(3,0,0);
    launch(8'h06, -1); wait_idle();
    rd(3'd1, d); chk("R5 write done", d, 8'h80);
    wr(3'd1, 0);

    // R6 read word
    push(0,0,0); push(1,8'hA0,0); push(1,8'h12,0); push(0,0,0); push(1,8'hA1,0);
    push(2,8'h11,0); push(2,8'h22,1); push(3,0,0);
    launch(8'h09, -1); wait_idle();
    rd(3'd4, d); chk("R6 word low", d, 8'h11);
    rd(3'd5, d); chk("R6 word high", d, 8'h22);
    wr(3'd1, 0);

    // R3 quick write and read
    push(0,0,0); push(1,8'hA0,0); push(3,0,0);
    launch(8'h02, -1); wait_idle();
    rd(3'd1, d); chk("R3 quick write done", d, 8'h80);
    wr(3'd1, 0);
    push(0,0,0); push(1,8'hA1,0); push(3,0,0);
    launch(8'h03, -1); wait_idle();
    rd(3'd1, d); chk("R3 quick read done", d, 8'h80);
    wr(3'd1, 0);

    // R4 send and receive byte
    push(0,0,0); push(1,8'hA0,0); push(1,8'h11,0); push(3,0,0);
    launch(8'h04, -1); wait_idle();
    rd(3'd1, d); chk("R4 send done", d, 8'h80);
    wr(3'd1, 0);
    push(0,0,0); push(1,8'hA1,0); push(2,8'h7E,1); push(3,0,0);
    launch(8'h05, -1); wait_idle();
    rd(3'd4, d); chk("R4 receive data0", d, 8'h7E);
    wr(3'd1, 0);

    // R8 NACK on command byte (op index 2)
    push(0,0,0); push(1,8'hA0,0); push(1,8'h12,0); push(3,0,0);
    launch(8'h08, 2); wait_idle();
    rd(3'd1, d); chk("R8 nack status", d, 8'h01);
    wr(3'd1, 0);

    // R9 undefined codes
    launch(8'h0A, -1); wait_idle();
    rd(3'd1, d); chk("R9 bad code 0x0A", d, 8'h02);
    chk("R9 no request", {7'd0, eng_req}, 8'h00);
    wr(3'd1, 0);
    launch(8'h00, -1); wait_idle();
    rd(3'd1, d); chk("R9 bad code 0x00", d, 8'h02);
    wr(3'd1, 0);

    // R11 clear collides with completion
    clr_on_stop = 1;
    push(0,0,0); push(1,8'hA0,0); push(3,0,0);
    launch(8'h02, -1); wait_idle();
    clr_on_stop = 0;
    rd(3'd1, d); chk("R11 completion kept over clear", d, 8'h80);

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule